// File: doc/BRIEF.md
# Mini UART Register Slave

This block is a 32-bit register slave that occupies a 256-byte address window and fronts a reduced serial port. Bytes arriving from a receiver come in on a valid/ready byte stream and are held in a circular receive queue. A software write to the data word sends its low byte out at once on a one-cycle transmit strobe, so the transmit side never holds anything. Baud timing, bit serialization, line and modem control, the scratch word, the divisor-latch mode and the SPI side are not built.

Software sees an interrupt-enable word, an interrupt-identification word, a line-status word and an extended-status word that carries the receive fill level in its upper half. A single level interrupt output is derived from the enable bits and the queue occupancy. The identification word reports receive data ahead of transmit, and writing it with bit 1 set throws away every queued byte. Register offsets are fixed because driver software decodes them: IRQ summary 0x00, enables 0x04, data 0x40, interrupt enable 0x44, interrupt ID 0x48, line status 0x54, control 0x60, extended status 0x64. The line control 0x4C, modem control 0x50, modem status 0x58, scratch 0x5C and baud 0x68 words are inert.

Top module: `mu_regif`

## Requirements
- R1: After reset the interrupt output, the response strobe and the transmit strobe are low, the receive queue is empty and rx_ready is high.
- R2: A read request returns its data with rsp_valid high in the cycle after the request; a write request produces no response strobe.
- R3: A write to the data word (0x40) raises tx_valid for exactly one cycle, in the cycle after the request, with tx_data equal to bits 7:0 of the write data.
- R4: Receive bytes are returned by data-word reads in arrival order, including when the read and write positions wrap around the 8-entry queue.
- R5: rx_ready is high only while fewer than 8 bytes are held; a byte offered while the queue is full is not stored.
- R6: A data-word read of an empty queue returns the byte in the slot at the read position, and leaves the occupancy at zero.
- R7: A write to the interrupt-enable word (0x44) keeps only bits 1:0 (bit 0 receive, bit 1 transmit); a read returns those bits ORed with 0xC0.
- R8: irq is high exactly when the transmit enable is set, or the receive enable is set and the queue is non-empty; the IRQ summary word (0x00) reads 1 when irq is high and 0 otherwise.
- R9: The interrupt-ID word (0x48) reads 0xC0 ORed with 0x4 when the queue holds data or 0x2 when it is empty, and further ORed with 0x1 when irq is low.
- R10: Writing the interrupt-ID word with bit 1 set empties the receive queue; a write with bit 1 clear leaves the queue unchanged.
- R11: The line-status word (0x54) reads 0x60, with bit 0 set while the queue holds data.
- R12: The extended-status word (0x64) reads 0x30E, with bit 0 set while the queue holds data and the occupancy count placed from bit 16 upward.
- R13: The enables word reads 1 and the control word reads 0x3; line control, modem control, modem status, scratch, baud, unmapped and misaligned offsets read 0; writes to enables, line control, modem control, scratch, control and baud change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request in this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 8 | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Queue can take a byte this cycle |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Level interrupt |

## Verification
Read data and the transmit strobe are registered, so both are due one cycle after the request edge, and the bench samples them one nanosecond after that edge, before anything else moves. Queue pushes, pops, flushes and enable writes take effect at the request edge, while irq and rx_ready follow combinationally from that new state; the bench therefore observes them at the next falling edge or through a later status read. Status words are compared against values the bench derives from its own count of bytes pushed, popped and flushed.

// File: rtl/mu_pkg.sv
package mu_pkg;
   // Word indices (byte offset / 4) that driver software decodes.
   localparam logic [5:0] W_IRQ_SUM = 6'h00;
   localparam logic [5:0] W_ENABLES = 6'h01;
   localparam logic [5:0] W_DATA    = 6'h10;
   localparam logic [5:0] W_IEN     = 6'h11;
   localparam logic [5:0] W_IID     = 6'h12;
   localparam logic [5:0] W_LSTAT   = 6'h15;
   localparam logic [5:0] W_CTRL    = 6'h18;
   localparam logic [5:0] W_XSTAT   = 6'h19;

   // Fixed status patterns.
   localparam logic [31:0] IID_BASE   = 32'h0000_00C0;
   localparam logic [31:0] IEN_BASE   = 32'h0000_00C0;
   localparam logic [31:0] LSTAT_BASE = 32'h0000_0060;
   localparam logic [31:0] XSTAT_BASE = 32'h0000_030E;
   localparam logic [31:0] CTRL_VAL   = 32'h0000_0003;
   localparam logic [31:0] ENA_VAL    = 32'h0000_0001;

   localparam int XSTAT_CNT_LSB = 16;

   typedef struct packed {
      logic       rx_en;
      logic       tx_en;
   } ien_t;
endpackage

// File: rtl/mu_rx_queue.sv
module mu_rx_queue #(
   parameter int DEPTH  = 8,
   parameter int BYTE_W = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [BYTE_W-1:0] push_data,
   input  logic              pop,
   input  logic              flush,
   output logic [BYTE_W-1:0] head,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic              nonempty
);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
   localparam logic [CNT_W:0]   DEPTH_W = (CNT_W + 1)'(DEPTH);
   localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

   logic [BYTE_W-1:0] slot_q [DEPTH];
   logic [PTR_W-1:0]  rd_ptr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [PTR_W-1:0]  wr_slot;
   logic [PTR_W-1:0]  rd_next;
   logic              do_push;
   logic              do_pop;

   assign full     = (cnt_q == DEPTH_C);
   assign nonempty = (cnt_q != '0);
   assign do_push  = push && !full && !flush;
   assign do_pop   = pop && nonempty && !flush;
   assign head     = slot_q[rd_ptr_q];
   assign count    = cnt_q;

   // Pointer arithmetic: natural wrap for power-of-two depths, compare otherwise.
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      logic [CNT_W:0] sum_full;
      assign sum_full = {{(CNT_W + 1 - PTR_W){1'b0}}, rd_ptr_q} + {1'b0, cnt_q};
      assign wr_slot  = sum_full[PTR_W-1:0];
      assign rd_next  = rd_ptr_q + PTR_W'(1);
   end else begin : g_mod
      logic [CNT_W:0] sum_full;
      logic [CNT_W:0] sum_wrap;
      assign sum_full = {{(CNT_W + 1 - PTR_W){1'b0}}, rd_ptr_q} + {1'b0, cnt_q};
      assign sum_wrap = (sum_full >= DEPTH_W) ? (sum_full - DEPTH_W) : sum_full;
      assign wr_slot  = sum_wrap[PTR_W-1:0];
      assign rd_next  = (rd_ptr_q == LAST_P) ? '0 : rd_ptr_q + PTR_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      end else if (do_push) begin
         slot_q[wr_slot] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (do_pop) rd_ptr_q <= rd_next;
         if (flush) begin
            cnt_q <= '0;
         end else begin
            case ({do_push, do_pop})
               2'b10:   cnt_q <= cnt_q + CNT_W'(1);
               2'b01:   cnt_q <= cnt_q - CNT_W'(1);
               default: cnt_q <= cnt_q;
            endcase
         end
      end
   end
endmodule

// File: rtl/mu_irq_ctrl.sv
module mu_irq_ctrl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ien_we,
   input  logic [1:0] ien_wdata,
   input  logic       rx_nonempty,
   output mu_pkg::ien_t ien,
   output logic       pending
);
   mu_pkg::ien_t ien_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q <= '0;
      end else if (ien_we) begin
         ien_q.rx_en <= ien_wdata[0];
         ien_q.tx_en <= ien_wdata[1];
      end
   end

   assign ien     = ien_q;
   // Transmit drains instantly, so its request is simply its enable.
   assign pending = (ien_q.rx_en && rx_nonempty) || ien_q.tx_en;
endmodule

// File: rtl/mu_reg_read.sv
module mu_reg_read #(
   parameter int CNT_W  = 4,
   parameter int BYTE_W = 8
) (
   input  logic [5:0]        word_idx,
   input  logic              aligned,
   input  mu_pkg::ien_t      ien,
   input  logic              pending,
   input  logic [CNT_W-1:0]  count,
   input  logic [BYTE_W-1:0] head,
   output logic [31:0]       rdata
);
   import mu_pkg::*;

   logic        nonempty;
   logic [31:0] iid_word;
   logic [31:0] xstat_word;
   logic [31:0] lstat_word;

   assign nonempty = (count != '0);

   always_comb begin
      iid_word = IID_BASE;
      iid_word[2] = nonempty;
      iid_word[1] = !nonempty;
      iid_word[0] = !pending;
   end

   always_comb begin
      lstat_word    = LSTAT_BASE;
      lstat_word[0] = nonempty;
   end

   always_comb begin
      xstat_word = XSTAT_BASE;
      xstat_word[0] = nonempty;
      xstat_word[XSTAT_CNT_LSB +: CNT_W] = count;
   end

   always_comb begin
      rdata = '0;
      if (aligned) begin
         case (word_idx)
            W_IRQ_SUM: rdata = {31'd0, pending};
            W_ENABLES: rdata = ENA_VAL;
            W_DATA:    rdata = {{(32 - BYTE_W){1'b0}}, head};
            W_IEN:     rdata = IEN_BASE | {30'd0, ien.tx_en, ien.rx_en};
            W_IID:     rdata = iid_word;
            W_LSTAT:   rdata = lstat_word;
            W_CTRL:    rdata = CTRL_VAL;
            W_XSTAT:   rdata = xstat_word;
            default:   rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/mu_regif.sv
module mu_regif #(
   parameter int DEPTH  = 8,
   parameter int BYTE_W = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [7:0]        req_addr,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_data,
   output logic              irq
);
   import mu_pkg::*;

   if (DEPTH < 2) begin : g_bad_depth
      $error("mu_regif: DEPTH must be at least 2");
   end
   if (BYTE_W < 1 || BYTE_W > 16) begin : g_bad_byte
      $error("mu_regif: BYTE_W must be 1..16");
   end
   if (XSTAT_CNT_LSB + CNT_W > 32) begin : g_bad_cnt
      $error("mu_regif: fill level does not fit the status word");
   end

   logic [5:0]        word_idx;
   logic              aligned;
   logic              wr_req;
   logic              rd_req;
   logic              hit_data;
   logic              hit_ien;
   logic              hit_iid;
   logic              q_flush;
   logic              q_pop;
   logic              q_full;
   logic              q_nonempty;
   logic [CNT_W-1:0]  q_count;
   logic [BYTE_W-1:0] q_head;
   ien_t              ien;
   logic              pending;
   logic [31:0]       rd_word;
   logic              rsp_valid_q;
   logic [31:0]       rsp_rdata_q;
   logic              tx_valid_q;
   logic [BYTE_W-1:0] tx_data_q;
   logic              unused_wdata_hi;

   assign word_idx = req_addr[7:2];
   assign aligned  = (req_addr[1:0] == 2'b00);
   assign wr_req   = req_valid && req_write;
   assign rd_req   = req_valid && !req_write;
   assign hit_data = aligned && (word_idx == W_DATA);
   assign hit_ien  = aligned && (word_idx == W_IEN);
   assign hit_iid  = aligned && (word_idx == W_IID);

   assign q_flush  = wr_req && hit_iid && req_wdata[1];
   assign q_pop    = rd_req && hit_data;
   assign rx_ready = !q_full && !q_flush;

   assign unused_wdata_hi = ^req_wdata[31:BYTE_W];

   mu_rx_queue #(
      .DEPTH  (DEPTH),
      .BYTE_W (BYTE_W)
   ) i_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rx_valid),
      .push_data (rx_data),
      .pop       (q_pop),
      .flush     (q_flush),
      .head      (q_head),
      .count     (q_count),
      .full      (q_full),
      .nonempty  (q_nonempty)
   );

   mu_irq_ctrl i_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .ien_we      (wr_req && hit_ien),
      .ien_wdata   (req_wdata[1:0]),
      .rx_nonempty (q_nonempty),
      .ien         (ien),
      .pending     (pending)
   );

   mu_reg_read #(
      .CNT_W  (CNT_W),
      .BYTE_W (BYTE_W)
   ) i_rdmux (
      .word_idx (word_idx),
      .aligned  (aligned),
      .ien      (ien),
      .pending  (pending),
      .count    (q_count),
      .head     (q_head),
      .rdata    (rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_rdata_q <= '0;
      end else begin
         rsp_valid_q <= rd_req;
         rsp_rdata_q <= rd_req ? rd_word : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid_q <= 1'b0;
         tx_data_q  <= '0;
      end else begin
         tx_valid_q <= wr_req && hit_data;
         if (wr_req && hit_data) tx_data_q <= req_wdata[BYTE_W-1:0];
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_rdata = rsp_rdata_q;
   assign tx_valid  = tx_valid_q;
   assign tx_data   = tx_data_q;
   assign irq       = pending;
endmodule

// File: rtl/mu_regif_chk.sv
module mu_regif_chk #(
   parameter int DEPTH  = 8,
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [7:0]        req_addr,
   input logic [31:0]       req_wdata,
   input logic              rsp_valid,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              tx_valid,
   input logic [BYTE_W-1:0] tx_data,
   input logic              irq,
   input logic [1:0]        ien_bits,
   input logic [CNT_W-1:0]  count
);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   logic wr_data_req;
   logic rd_data_req;
   logic wr_flush_req;
   assign wr_data_req  = req_valid && req_write  && (req_addr == 8'h40);
   assign rd_data_req  = req_valid && !req_write && (req_addr == 8'h40);
   assign wr_flush_req = req_valid && req_write  && (req_addr == 8'h48) && req_wdata[1];

   // R2: read answered next cycle, writes not answered
   p_read_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid);
   p_write_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> !rsp_valid);

   // R3: data write strobes the transmit byte next cycle
   p_tx_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data_req |=> (tx_valid && tx_data == $past(req_wdata[BYTE_W-1:0])));
   p_tx_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_data_req |=> !tx_valid);

   // R5: no overflow, no ready while full
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      count <= DEPTH_C);
   p_full_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (count == DEPTH_C) |-> !rx_ready);

   // R6: empty data read without push keeps the queue empty
   p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_req && count == '0 && !(rx_valid && rx_ready)) |=> (count == '0));

   // R4: a pop without push takes exactly one byte
   p_pop_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_req && count != '0 && !(rx_valid && rx_ready)) |=>
      (count == $past(count) - CNT_W'(1)));

   // R8: interrupt level follows enables and occupancy
   p_irq_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ien_bits[1] |-> irq);
   p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ien_bits[1] && (!ien_bits[0] || count == '0)) |-> !irq);

   // R10: flush empties the queue
   p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_flush_req |=> (count == '0));
endmodule

bind mu_regif mu_regif_chk #(
   .DEPTH  (DEPTH),
   .BYTE_W (BYTE_W),
   .CNT_W  (CNT_W)
) i_mu_regif_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_wdata (req_wdata),
   .rsp_valid (rsp_valid),
   .rx_valid  (rx_valid),
   .rx_ready  (rx_ready),
   .tx_valid  (tx_valid),
   .tx_data   (tx_data),
   .irq       (irq),
   .ien_bits  ({ien.tx_en, ien.rx_en}),
   .count     (q_count)
);

// File: tb/test_mu_regif.sv
`timescale 1ns/1ps
module test_mu_regif;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_ready;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mu_regif i_mu_regif (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata),
      .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
      .rx_valid (rx_valid), .rx_data (rx_data), .rx_ready (rx_ready),
      .tx_valid (tx_valid), .tx_data (tx_data), .irq (irq)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(posedge clk); #1;
      req_valid = 1'b0; req_write = 1'b0;
      check(rsp_valid == 1'b0, "R2 write no response", 32'(rsp_valid), 0);
      if (a == 8'h40) begin
         check(tx_valid == 1'b1 && tx_data == d[7:0], "R3 tx strobe",
               {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, d[7:0]});
         @(posedge clk); #1;
         check(tx_valid == 1'b0, "R3 tx single cycle", 32'(tx_valid), 0);
      end else begin
         check(tx_valid == 1'b0, "R3 no tx for other words", 32'(tx_valid), 0);
      end
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(posedge clk); #1;
      req_valid = 1'b0;
      check(rsp_valid == 1'b1, "R2 read response valid", 32'(rsp_valid), 1);
      d = rsp_rdata;
   endtask

   task automatic read_expect(input logic [7:0] a, input logic [31:0] exp,
                              input string req);
      logic [31:0] d;
      bus_read(a, d);
      check(d == exp, req, d, exp);
   endtask

   task automatic push(input logic [7:0] b, input bit exp_ready);
      @(negedge clk);
      check(rx_ready == exp_ready, "R5 rx_ready level", 32'(rx_ready), 32'(exp_ready));
      rx_valid = 1'b1; rx_data = b;
      @(posedge clk); #1;
      rx_valid = 1'b0;
   endtask

   function automatic logic [31:0] xstat(input int n);
      return 32'h30E | (n != 0 ? 32'h1 : 32'h0) | (32'(n) << 16);
   endfunction

   task automatic t_reset;
      @(negedge clk);
      check(irq == 1'b0, "R1 irq low", 32'(irq), 0);
      check(rx_ready == 1'b1, "R1 rx_ready high", 32'(rx_ready), 1);
      check(tx_valid == 1'b0 && rsp_valid == 1'b0, "R1 strobes low",
            {30'd0, tx_valid, rsp_valid}, 0);
      read_expect(8'h54, 32'h60, "R1 R11 empty line status");
      read_expect(8'h64, xstat(0), "R1 R12 empty ext status");
   endtask

   task automatic t_fill_and_stale;
      for (int i = 0; i < 8; i++) push(8'hA0 + 8'(i), 1'b1);
      push(8'hEE, 1'b0);
      read_expect(8'h64, xstat(8), "R12 R5 full ext status");
      read_expect(8'h54, 32'h61, "R11 data available");
      for (int i = 0; i < 8; i++) read_expect(8'h40, 32'hA0 + 32'(i), "R4 R5 order");
      read_expect(8'h40, 32'hA0, "R6 stale slot on empty read");
      read_expect(8'h54, 32'h60, "R6 still empty");
   endtask

   task automatic t_wrap;
      for (int i = 0; i < 3; i++) push(8'hB0 + 8'(i), 1'b1);
      read_expect(8'h40, 32'hB0, "R4 wrap first");
      read_expect(8'h40, 32'hB1, "R4 wrap second");
      for (int i = 0; i < 7; i++) push(8'hC0 + 8'(i), 1'b1);
      read_expect(8'h64, xstat(8), "R12 count after wrap");
      read_expect(8'h40, 32'hB2, "R4 wrap head");
      for (int i = 0; i < 7; i++) read_expect(8'h40, 32'hC0 + 32'(i), "R4 wrap order");
      read_expect(8'h64, xstat(0), "R12 drained");
   endtask

   task automatic t_tx;
      bus_write(8'h40, 32'h1234_5655);
      bus_write(8'h40, 32'h0000_00AA);
   endtask

   task automatic t_irq;
      bus_write(8'h44, 32'hFFFF_FFFF);
      read_expect(8'h44, 32'hC3, "R7 enable mask");
      @(negedge clk);
      check(irq == 1'b1, "R8 tx enable raises irq", 32'(irq), 1);
      read_expect(8'h00, 32'h1, "R8 summary set");
      read_expect(8'h48, 32'hC2, "R9 tx id empty");
      bus_write(8'h44, 32'h1);
      @(negedge clk);
      check(irq == 1'b0, "R8 rx enable empty queue", 32'(irq), 0);
      read_expect(8'h00, 32'h0, "R8 summary clear");
      read_expect(8'h48, 32'hC3, "R9 no pending");
      push(8'h5A, 1'b1);
      @(negedge clk);
      check(irq == 1'b1, "R8 rx data raises irq", 32'(irq), 1);
      read_expect(8'h48, 32'hC4, "R9 rx priority");
      bus_write(8'h44, 32'h0);
      read_expect(8'h48, 32'hC5, "R9 data but disabled");
      read_expect(8'h44, 32'hC0, "R7 cleared enables");
      read_expect(8'h40, 32'h5A, "R4 single byte");
   endtask

   task automatic t_flush;
      push(8'h11, 1'b1);
      push(8'h22, 1'b1);
      bus_write(8'h48, 32'h4);
      read_expect(8'h64, xstat(2), "R10 bit1 clear keeps queue");
      bus_write(8'h48, 32'h2);
      read_expect(8'h64, xstat(0), "R10 flush empties");
      read_expect(8'h54, 32'h60, "R10 R11 after flush");
   endtask

   task automatic t_inert;
      push(8'h33, 1'b1);
      bus_write(8'h44, 32'h1);
      bus_write(8'h04, 32'hFFFF_FFFF);
      bus_write(8'h4C, 32'hFFFF_FFFF);
      bus_write(8'h50, 32'hFFFF_FFFF);
      bus_write(8'h5C, 32'hFFFF_FFFF);
      bus_write(8'h60, 32'h0);
      bus_write(8'h68, 32'hFFFF_FFFF);
      bus_write(8'h41, 32'h77);
      read_expect(8'h04, 32'h1, "R13 enables word");
      read_expect(8'h60, 32'h3, "R13 control word");
      read_expect(8'h4C, 32'h0, "R13 line control");
      read_expect(8'h50, 32'h0, "R13 modem control");
      read_expect(8'h58, 32'h0, "R13 modem status");
      read_expect(8'h5C, 32'h0, "R13 scratch");
      read_expect(8'h68, 32'h0, "R13 baud");
      read_expect(8'h80, 32'h0, "R13 unmapped");
      read_expect(8'h42, 32'h0, "R13 misaligned");
      read_expect(8'h44, 32'hC1, "R13 enables untouched");
      read_expect(8'h64, xstat(1), "R13 queue untouched");
      read_expect(8'h40, 32'h33, "R13 byte intact");
      bus_write(8'h44, 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_fill_and_stale();
      t_wrap();
      t_tx();
      t_irq();
      t_flush();
      t_inert();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule